// File: doc/BRIEF.md
# Load Address Generation Unit

This block sits in the address stage of a 32-bit load/store pipeline. For each request it forms an offset from one of three sources: a constant operand, an index register, or an index register shifted left by zero to three places. It adds that offset to a base register value or subtracts it. Depending on the addressing mode, it then presents either the adjusted value or the untouched base as the memory address. It also produces the value and the enable for writing the base register back. All of these outputs are registered and become valid one clock after the request.

When the memory later returns a 32-bit little-endian word for a byte load, the block picks the byte lane given by the low two bits of the most recently issued address. It then widens that byte to 32 bits, either filling the upper bits with zeros or replicating the byte's top bit, depending on the signedness captured with the request. The extended value is also registered and appears one clock after the response strobe.

Top module: `agu_load_stage`

## Requirements
- R1: While `rst` is high, at the next clock edge `addr_valid`, `wb_en` and `ld_valid` go low and `addr`, `wb_data` and `ld_data` become zero.
- R2: With `sub_off` = 1 the adjusted value is base minus offset modulo 2^32; with `sub_off` = 0 it is base plus offset modulo 2^32.
- R3: With `mode` = 2'b00 (offset), `addr` equals the adjusted value and `wb_en` stays low.
- R4: With `mode` = 2'b01 (pre-indexed), `addr` and `wb_data` both equal the adjusted value and `wb_en` is high.
- R5: With `mode` = 2'b10 (post-indexed), `addr` equals the unmodified base, `wb_data` equals the adjusted value and `wb_en` is high.
- R6: `off_src` picks the offset: 2'b00 the `imm` operand, 2'b01 `index`, 2'b10 `index` shifted left by `shamt`; 2'b11 is treated as 2'b00.
- R7: The shifted index is `index << shamt` for `shamt` 0 to 3, truncated to 32 bits so bits shifted past bit 31 are lost.
- R8: For an unsigned byte load (`ld_signed` = 0 at request time), `ld_data[7:0]` holds the selected byte and `ld_data[31:8]` is zero.
- R9: For a signed byte load (`ld_signed` = 1 at request time), `ld_data[31:8]` is filled with copies of bit 7 of the selected byte.
- R10: The selected byte lane is the low two bits of the issued `addr`, little-endian: lane 0 is `rdata[7:0]`, lane 3 is `rdata[31:24]`. In post-indexed mode this is the base's low bits.
- R11: `addr`, `wb_data`, `wb_en` and `addr_valid` update one cycle after a request with `req_valid` high. Without a request `addr_valid` and `wb_en` are low the next cycle. `ld_data` and `ld_valid` update one cycle after `rsp_valid`.
- R12: `mode` = 2'b11 behaves as offset mode: the address is the adjusted value and `wb_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request strobe |
| mode | input | 2 | Addressing mode: 00 offset, 01 pre-indexed, 10 post-indexed, 11 as offset |
| sub_off | input | 1 | 1 subtracts the offset, 0 adds it |
| off_src | input | 2 | Offset source: 00 constant, 01 index, 10 shifted index, 11 as constant |
| base | input | 32 | Base register value |
| imm | input | 32 | Constant offset operand |
| index | input | 32 | Index register value |
| shamt | input | 2 | Left shift applied to the index for source 10 |
| ld_signed | input | 1 | Byte load signedness, captured with the request |
| rsp_valid | input | 1 | Returned read word strobe |
| rdata | input | 32 | Returned little-endian read word |
| addr | output | 32 | Effective memory address |
| addr_valid | output | 1 | Address outputs valid |
| wb_data | output | 32 | Base register writeback value |
| wb_en | output | 1 | Base register writeback enable |
| ld_data | output | 32 | Extended byte load result |
| ld_valid | output | 1 | Load result valid |

## Verification
On every cycle, the assertions check the relations that hold whatever the operand values are. A writeback never appears without a valid address, and offset-mode requests never write back. A pre-indexed address always equals its writeback value, and a post-indexed address always equals the base from the previous cycle. Every load result has upper bits that are either all zero or all one, copying bit 7, and the one-cycle timing of both paths is checked as well. Only the bench's directed scenarios can show that the arithmetic values are right. That covers subtraction wrapping below zero, the offset source decode, the shift truncation at bit 31, the choice of the correct byte lane from the issued address, and whether the zero-fill or the sign-fill was applied.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'b00,
    AM_PRE    = 2'b01,
    AM_POST   = 2'b10,
    AM_RSVD   = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    OS_CONST   = 2'b00,
    OS_INDEX   = 2'b01,
    OS_SHIFTED = 2'b10,
    OS_RSVD    = 2'b11
  } off_src_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
  import agu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 2
) (
  input  logic [1:0]         src,
  input  logic [DATA_W-1:0]  imm,
  input  logic [DATA_W-1:0]  index,
  input  logic [SHIFT_W-1:0] shamt,
  output logic [DATA_W-1:0]  offset
);

  logic [DATA_W-1:0] shifted;
  off_src_e          src_e;

  // Left shift keeps only DATA_W bits; upper bits fall off.
  assign shifted = index << shamt;
  assign src_e   = off_src_e'(src);

  always_comb begin
    unique case (src_e)
      OS_INDEX:   offset = index;
      OS_SHIFTED: offset = shifted;
      default:    offset = imm;
    endcase
  end

endmodule

// File: rtl/agu_addr_calc.sv
module agu_addr_calc
  import agu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        mode,
  input  logic              sub_off,
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] offset,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wb_value,
  output logic              wb_en
);

  logic [DATA_W-1:0] adjusted;
  addr_mode_e        mode_e;

  assign adjusted = sub_off ? (base - offset) : (base + offset);
  assign mode_e   = addr_mode_e'(mode);
  assign wb_value = adjusted;

  always_comb begin
    unique case (mode_e)
      AM_PRE: begin
        addr  = adjusted;
        wb_en = 1'b1;
      end
      AM_POST: begin
        addr  = base;
        wb_en = 1'b1;
      end
      default: begin
        addr  = adjusted;
        wb_en = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/agu_byte_extract.sv
module agu_byte_extract
  import agu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES  = DATA_W / BYTE_W,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [LANE_W-1:0] lane,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] result
);

  logic [BYTE_W-1:0] lane_bytes [LANES];
  logic [BYTE_W-1:0] picked;

  // Little-endian: lane k occupies bits starting at k*8.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bytes[k] = word[k*BYTE_W +: BYTE_W];
  end

  assign picked = lane_bytes[lane];

  always_comb begin
    result = {{(DATA_W-BYTE_W){sign_ext & picked[BYTE_W-1]}}, picked};
  end

endmodule

// File: rtl/agu_load_stage.sv
module agu_load_stage
  import agu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [1:0]         mode,
  input  logic               sub_off,
  input  logic [1:0]         off_src,
  input  logic [DATA_W-1:0]  base,
  input  logic [DATA_W-1:0]  imm,
  input  logic [DATA_W-1:0]  index,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               ld_signed,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  addr,
  output logic               addr_valid,
  output logic [DATA_W-1:0]  wb_data,
  output logic               wb_en,
  output logic [DATA_W-1:0]  ld_data,
  output logic               ld_valid
);

  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned LANE_W = $clog2(LANES);

  logic [DATA_W-1:0] offset_c;
  logic [DATA_W-1:0] addr_c;
  logic [DATA_W-1:0] wb_c;
  logic              wb_en_c;
  logic [DATA_W-1:0] ext_c;
  logic [LANE_W-1:0] lane_q;
  logic              sign_q;

  agu_offset_sel #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_off (
    .src    (off_src),
    .imm    (imm),
    .index  (index),
    .shamt  (shamt),
    .offset (offset_c)
  );

  agu_addr_calc #(.DATA_W(DATA_W)) u_calc (
    .mode     (mode),
    .sub_off  (sub_off),
    .base     (base),
    .offset   (offset_c),
    .addr     (addr_c),
    .wb_value (wb_c),
    .wb_en    (wb_en_c)
  );

  agu_byte_extract #(.DATA_W(DATA_W)) u_ext (
    .word     (rdata),
    .lane     (lane_q),
    .sign_ext (sign_q),
    .result   (ext_c)
  );

  // Address-side registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr       <= '0;
      wb_data    <= '0;
      wb_en      <= 1'b0;
      addr_valid <= 1'b0;
      lane_q     <= '0;
      sign_q     <= 1'b0;
    end else begin
      addr_valid <= req_valid;
      wb_en      <= req_valid & wb_en_c;
      if (req_valid) begin
        addr    <= addr_c;
        wb_data <= wb_c;
        lane_q  <= addr_c[LANE_W-1:0];
        sign_q  <= ld_signed;
      end
    end
  end

  // Load-side registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_data  <= '0;
      ld_valid <= 1'b0;
    end else begin
      ld_valid <= rsp_valid;
      if (rsp_valid) begin
        ld_data <= ext_c;
      end
    end
  end

endmodule

// File: rtl/agu_load_stage_chk.sv
module agu_load_stage_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHIFT_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         mode,
  input logic [DATA_W-1:0]  base,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  addr,
  input logic               addr_valid,
  input logic [DATA_W-1:0]  wb_data,
  input logic               wb_en,
  input logic [DATA_W-1:0]  ld_data,
  input logic               ld_valid
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!addr_valid && !wb_en && !ld_valid && addr == '0 && ld_data == '0));

  p_offset_no_wb_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 2'b00) |=> !wb_en);

  p_pre_addr_eq_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 2'b01) |=> (wb_en && addr == wb_data));

  p_post_base_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 2'b10) |=> (wb_en && addr == $past(base)));

  p_ext_shape_r9: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}
                  || ld_data[DATA_W-1:8] == '0));

  p_req_latency_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> addr_valid);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!addr_valid && !wb_en));

  p_rsp_latency_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> ld_valid);

  p_rsvd_no_wb_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 2'b11) |=> !wb_en);

endmodule

bind agu_load_stage agu_load_stage_chk #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) chk_i (.*);

// File: tb/agu_load_stage_tb_top.sv
module agu_load_stage_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  mode;
  logic        sub_off;
  logic [1:0]  off_src;
  logic [31:0] base, imm, index;
  logic [1:0]  shamt;
  logic        ld_signed;
  logic        rsp_valid;
  logic [31:0] rdata;
  logic [31:0] addr, wb_data, ld_data;
  logic        addr_valid, wb_en, ld_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  agu_load_stage dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .sub_off(sub_off),
    .off_src(off_src), .base(base), .imm(imm), .index(index), .shamt(shamt),
    .ld_signed(ld_signed), .rsp_valid(rsp_valid), .rdata(rdata),
    .addr(addr), .addr_valid(addr_valid), .wb_data(wb_data), .wb_en(wb_en),
    .ld_data(ld_data), .ld_valid(ld_valid)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model_off(logic [1:0] src, logic [31:0] i,
                                            logic [31:0] x, logic [1:0] s);
    logic [63:0] wide;
    wide = {32'h0, x} << s;
    case (src)
      2'b01:   return x;
      2'b10:   return wide[31:0];
      default: return i;
    endcase
  endfunction

  // Issue one request; outputs are sampled at the following negedge.
  task automatic issue(logic [1:0] m, logic s, logic [1:0] src, logic [31:0] b,
                       logic [31:0] i, logic [31:0] x, logic [1:0] sh, logic sg);
    req_valid = 1'b1; mode = m; sub_off = s; off_src = src;
    base = b; imm = i; index = x; shamt = sh; ld_signed = sg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic respond(logic [31:0] w);
    rsp_valid = 1'b1; rdata = w;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic test_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 addr_valid", {31'b0, addr_valid}, 32'd0);
    check("R1 wb_en", {31'b0, wb_en}, 32'd0);
    check("R1 ld_valid", {31'b0, ld_valid}, 32'd0);
    check("R1 addr", addr, 32'd0);
    check("R1 ld_data", ld_data, 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_offset_mode;
    issue(2'b00, 1'b0, 2'b00, 32'h0000_1000, 32'h0000_0024, 32'h0, 2'd0, 1'b0);
    check("R3 addr", addr, 32'h0000_1024);
    check("R3 wb_en", {31'b0, wb_en}, 32'd0);
    check("R11 addr_valid", {31'b0, addr_valid}, 32'd1);
  endtask

  task automatic test_subtract;
    issue(2'b00, 1'b1, 2'b00, 32'h0000_0004, 32'h0000_0010, 32'h0, 2'd0, 1'b0);
    check("R2 wrap below zero", addr, 32'hFFFF_FFF4);
    issue(2'b00, 1'b0, 2'b00, 32'hFFFF_FFFC, 32'h0000_0008, 32'h0, 2'd0, 1'b0);
    check("R2 wrap above max", addr, 32'h0000_0004);
  endtask

  task automatic test_pre_mode;
    issue(2'b01, 1'b1, 2'b01, 32'h2000_0100, 32'h0, 32'h0000_0040, 2'd0, 1'b0);
    check("R4 addr", addr, 32'h2000_00C0);
    check("R4 wb_data", wb_data, 32'h2000_00C0);
    check("R4 wb_en", {31'b0, wb_en}, 32'd1);
  endtask

  task automatic test_post_mode;
    issue(2'b10, 1'b0, 2'b00, 32'h3000_0000, 32'h0000_0001, 32'h0, 2'd0, 1'b0);
    check("R5 addr", addr, 32'h3000_0000);
    check("R5 wb_data", wb_data, 32'h3000_0001);
    check("R5 wb_en", {31'b0, wb_en}, 32'd1);
  endtask

  task automatic test_sources;
    for (int src = 0; src < 4; src++) begin
      issue(2'b00, 1'b0, src[1:0], 32'h0001_0000, 32'h0000_0111, 32'h0000_0222, 2'd2, 1'b0);
      check("R6 source", addr, 32'h0001_0000 + model_off(src[1:0], 32'h111, 32'h222, 2'd2));
    end
  endtask

  task automatic test_shift;
    for (int sh = 0; sh < 4; sh++) begin
      issue(2'b00, 1'b0, 2'b10, 32'h0, 32'h0, 32'hC000_0003, sh[1:0], 1'b0);
      check("R7 shift trunc", addr, model_off(2'b10, 32'h0, 32'hC000_0003, sh[1:0]));
    end
  endtask

  task automatic test_zero_ext;
    issue(2'b00, 1'b0, 2'b00, 32'h0000_0100, 32'h1, 32'h0, 2'd0, 1'b0);
    respond(32'h11_22_F3_44);
    check("R8 unsigned lane1", ld_data, 32'h0000_00F3);
    check("R11 ld_valid", {31'b0, ld_valid}, 32'd1);
  endtask

  task automatic test_sign_ext;
    issue(2'b00, 1'b0, 2'b00, 32'h0000_0100, 32'h2, 32'h0, 2'd0, 1'b1);
    respond(32'h11_85_33_44);
    check("R9 signed negative", ld_data, 32'hFFFF_FF85);
    issue(2'b00, 1'b0, 2'b00, 32'h0000_0100, 32'h0, 32'h0, 2'd0, 1'b1);
    respond(32'h11_85_33_7F);
    check("R9 signed positive", ld_data, 32'h0000_007F);
  endtask

  task automatic test_lanes;
    for (int ln = 0; ln < 4; ln++) begin
      issue(2'b00, 1'b0, 2'b00, 32'h0000_0400, ln, 32'h0, 2'd0, 1'b0);
      respond(32'hD4_C3_B2_A1);
      check("R10 lane", ld_data, {24'h0, 8'hA1 + 8'(ln * 8'h11)});
    end
    // Post-indexed: lane from base (3), not the written-back value.
    issue(2'b10, 1'b0, 2'b00, 32'h0000_0403, 32'h1, 32'h0, 2'd0, 1'b0);
    respond(32'hD4_C3_B2_A1);
    check("R10 post lane", ld_data, 32'h0000_00D4);
  endtask

  task automatic test_idle;
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 idle valid", {31'b0, addr_valid}, 32'd0);
    check("R11 idle wb_en", {31'b0, wb_en}, 32'd0);
    check("R11 idle ld_valid", {31'b0, ld_valid}, 32'd0);
  endtask

  task automatic test_reserved_mode;
    issue(2'b11, 1'b0, 2'b00, 32'h0000_5000, 32'h0000_0008, 32'h0, 2'd0, 1'b0);
    check("R12 addr", addr, 32'h0000_5008);
    check("R12 wb_en", {31'b0, wb_en}, 32'd0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; mode = 2'b00; sub_off = 1'b0; off_src = 2'b00;
    base = '0; imm = '0; index = '0; shamt = '0; ld_signed = 1'b0;
    rsp_valid = 1'b0; rdata = '0;
    @(negedge clk);
    test_reset();
    test_offset_mode();
    test_subtract();
    test_pre_mode();
    test_post_mode();
    test_sources();
    test_shift();
    test_zero_ext();
    test_sign_ext();
    test_lanes();
    test_idle();
    test_reserved_mode();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule